// File: doc/BRIEF.md
# Translation Lookaside Buffer with Locked-Entry Region

This block is a single translation lookaside buffer shared by instruction fetches and data accesses. It holds virtual-to-physical page translations in two stores that are searched in the same cycle. A small fully-associative store keeps locked translations. A larger two-way set-associative store keeps every other translation and replaces its entries with a per-set round-robin pointer. When both stores match, the locked store supplies the result.

Lookups arrive on a valid/ready request stream and leave on a valid/ready response stream. The response carries a hit flag and a physical page number and is registered. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The response is valid on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds and `req_ready` stays low.

Entry writes, lock control loads and invalidations are plain single-cycle strobes. The lock control register is sampled when an entry is written, and its keep bit decides which store receives the entry. When `mmu_en` is low, translation is bypassed and every stored entry is kept.

Top module: `xlat_buffer`

## Requirements
- R1: A request accepted at a clock edge produces `rsp_valid` high in the following cycle, with the lookup made against the store contents as they stood before that edge.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_hit` and `rsp_ppn` are held, `rsp_valid` stays high and `req_ready` is low.
- R3: If `mmu_en` is low when a request is accepted, the response has `rsp_hit`=1 and `rsp_ppn` equal to the request's page number.
- R4: A write made while the lock keep bit is 0 goes to set `wr_vpn[4:0]` of the set-associative store. The way is the set's round-robin pointer, which starts at way 0 and advances on each write to that set, so a third write to one set evicts the first.
- R5: A write made while the keep bit is 1 goes to the locked slot named by the lock slot register. That register then advances by one, modulo 8, so the ninth locked write after a load overwrites the first slot written.
- R6: `inv_all` clears every set-associative entry and leaves every locked entry valid.
- R7: `inv_va` clears every valid entry in both stores whose page number equals `inv_vpn`, and no other entry.
- R8: When both stores hold the looked-up page, the locked store's physical page is returned.
- R9: Entries written while translation is on are still valid after `mmu_en` goes low and then high again.
- R10: A lookup that matches no entry while translation is on returns `rsp_hit`=0 and `rsp_ppn`=0.
- R11: Commands in one cycle follow the priority `inv_all` over `inv_va` over `wr_en`, and the lower-priority command is dropped. A write in the same cycle as `lock_load` uses the old keep bit and slot. `lock_load` sets the slot to `lock_slot` and the keep bit to `lock_keep` for the next cycle.
- R12: After reset, both stores are empty, the lock slot is 0, the keep bit is 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable, sampled with each accepted request |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vpn | input | PN_W | Virtual page number to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response; low stalls |
| rsp_hit | output | 1 | Translation found, or bypass |
| rsp_ppn | output | PN_W | Physical page number |
| wr_en | input | 1 | Write one entry |
| wr_vpn | input | PN_W | Virtual page of the written entry |
| wr_ppn | input | PN_W | Physical page of the written entry |
| lock_load | input | 1 | Load the lock control register |
| lock_slot | input | LK_W | New locked-slot index |
| lock_keep | input | 1 | New keep bit (1 = writes go to locked store) |
| inv_all | input | 1 | Clear the set-associative store |
| inv_va | input | 1 | Clear entries matching `inv_vpn` |
| inv_vpn | input | PN_W | Page number for invalidate-by-address |

## Verification
The lookup is tried with several patterns. A cold miss, a bypass and single hits show plain translation. Three writes to one set separate round-robin eviction from an overwrite that picks the first free way. A run of ten locked writes across the slot wrap shows whether the slot counter advances modulo eight. A page held in both stores, read before and after `inv_all` and `inv_va`, shows the locked store's priority and which invalidation reaches which store. Same-cycle command pairs and a stalled response, with a second request waiting behind it, show the command priority and the back-pressure rule.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_WRITE   = 2'd1,
    CMD_INV_VA  = 2'd2,
    CMD_INV_ALL = 2'd3
  } xlat_cmd_e;
endpackage

// File: rtl/xlat_lock_ctrl.sv
module xlat_lock_ctrl #(
  parameter int LOCK_N = 8,
  localparam int LK_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LK_W-1:0] load_slot,
  input  logic            load_keep,
  input  logic            advance,
  output logic            keep_q,
  output logic [LK_W-1:0] victim_q
);
  localparam logic [LK_W-1:0] LAST = LK_W'(LOCK_N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q   <= 1'b0;
      victim_q <= '0;
    end else if (load) begin
      keep_q   <= load_keep;
      victim_q <= load_slot;
    end else if (advance) begin
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_lock_store.sv
module xlat_lock_store #(
  parameter int PN_W   = 20,
  parameter int LOCK_N = 8,
  localparam int LK_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [LK_W-1:0] wr_slot,
  input  logic [PN_W-1:0] wr_vpn,
  input  logic [PN_W-1:0] wr_ppn,
  input  logic            inv_va,
  input  logic [PN_W-1:0] inv_vpn,
  input  logic [PN_W-1:0] lu_vpn,
  output logic            lu_hit,
  output logic [PN_W-1:0] lu_ppn
);
  logic [LOCK_N-1:0] valid_q;
  logic [PN_W-1:0]   vpn_q [LOCK_N];
  logic [PN_W-1:0]   ppn_q [LOCK_N];
  logic [LOCK_N-1:0] lu_match;
  logic [LOCK_N-1:0] inv_match;

  genvar g;
  generate
    for (g = 0; g < LOCK_N; g++) begin : g_cmp
      assign lu_match[g]  = valid_q[g] && (vpn_q[g] == lu_vpn);
      assign inv_match[g] = valid_q[g] && (vpn_q[g] == inv_vpn);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (inv_va) begin
      valid_q <= valid_q & ~inv_match;
    end else if (we) begin
      valid_q[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !inv_va) begin
      vpn_q[wr_slot] <= wr_vpn;
      ppn_q[wr_slot] <= wr_ppn;
    end
  end

  always_comb begin
    lu_hit = |lu_match;
    lu_ppn = '0;
    for (int i = 0; i < LOCK_N; i++) begin
      if (lu_match[i]) lu_ppn = lu_ppn | ppn_q[i];
    end
  end
endmodule

// File: rtl/xlat_set_store.sv
module xlat_set_store #(
  parameter int PN_W  = 20,
  parameter int SET_N = 32,
  parameter int WAY_N = 2,
  localparam int IDX_W = $clog2(SET_N),
  localparam int TAG_W = PN_W - IDX_W,
  localparam int WAY_W = (WAY_N > 1) ? $clog2(WAY_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PN_W-1:0] wr_vpn,
  input  logic [PN_W-1:0] wr_ppn,
  input  logic            inv_all,
  input  logic            inv_va,
  input  logic [PN_W-1:0] inv_vpn,
  input  logic [PN_W-1:0] lu_vpn,
  output logic            lu_hit,
  output logic [PN_W-1:0] lu_ppn
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAY_N - 1);

  logic [WAY_N-1:0] valid_q [SET_N];
  logic [TAG_W-1:0] tag_q   [SET_N][WAY_N];
  logic [PN_W-1:0]  ppn_q   [SET_N][WAY_N];
  logic [WAY_W-1:0] rr_q    [SET_N];

  logic [IDX_W-1:0] wr_idx, inv_idx, lu_idx;
  logic [TAG_W-1:0] wr_tag, inv_tag, lu_tag;
  logic [WAY_N-1:0] lu_match, inv_match;
  logic [WAY_W-1:0] wr_way;

  assign wr_idx  = wr_vpn[IDX_W-1:0];
  assign wr_tag  = wr_vpn[PN_W-1:IDX_W];
  assign inv_idx = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[PN_W-1:IDX_W];
  assign lu_idx  = lu_vpn[IDX_W-1:0];
  assign lu_tag  = lu_vpn[PN_W-1:IDX_W];
  assign wr_way  = rr_q[wr_idx];

  genvar w;
  generate
    for (w = 0; w < WAY_N; w++) begin : g_way
      assign lu_match[w]  = valid_q[lu_idx][w]  && (tag_q[lu_idx][w]  == lu_tag);
      assign inv_match[w] = valid_q[inv_idx][w] && (tag_q[inv_idx][w] == inv_tag);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SET_N; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (inv_all) begin
      for (int s = 0; s < SET_N; s++) valid_q[s] <= '0;
    end else if (inv_va) begin
      valid_q[inv_idx] <= valid_q[inv_idx] & ~inv_match;
    end else if (we) begin
      valid_q[wr_idx][wr_way] <= 1'b1;
      rr_q[wr_idx] <= (wr_way == LAST_WAY) ? '0 : wr_way + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !inv_all && !inv_va) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      ppn_q[wr_idx][wr_way] <= wr_ppn;
    end
  end

  always_comb begin
    lu_hit = |lu_match;
    lu_ppn = '0;
    for (int i = 0; i < WAY_N; i++) begin
      if (lu_match[i]) lu_ppn = lu_ppn | ppn_q[lu_idx][i];
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int PN_W   = 20,
  parameter int SET_N  = 32,
  parameter int WAY_N  = 2,
  parameter int LOCK_N = 8,
  localparam int LK_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mmu_en,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PN_W-1:0] req_vpn,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic [PN_W-1:0] rsp_ppn,
  input  logic            wr_en,
  input  logic [PN_W-1:0] wr_vpn,
  input  logic [PN_W-1:0] wr_ppn,
  input  logic            lock_load,
  input  logic [LK_W-1:0] lock_slot,
  input  logic            lock_keep,
  input  logic            inv_all,
  input  logic            inv_va,
  input  logic [PN_W-1:0] inv_vpn
);
  import xlat_pkg::*;

  xlat_cmd_e       cmd;
  logic            keep_q;
  logic [LK_W-1:0] victim_q;
  logic            lk_we, sa_we, do_inv_va, do_inv_all;
  logic            lk_hit, sa_hit;
  logic [PN_W-1:0] lk_ppn, sa_ppn;
  logic            fire;

  always_comb begin
    if (inv_all)     cmd = CMD_INV_ALL;
    else if (inv_va) cmd = CMD_INV_VA;
    else if (wr_en)  cmd = CMD_WRITE;
    else             cmd = CMD_IDLE;
  end

  assign lk_we      = (cmd == CMD_WRITE) && keep_q;
  assign sa_we      = (cmd == CMD_WRITE) && !keep_q;
  assign do_inv_va  = (cmd == CMD_INV_VA);
  assign do_inv_all = (cmd == CMD_INV_ALL);

  xlat_lock_ctrl #(.LOCK_N(LOCK_N)) u_lock_ctrl (
    .clk(clk), .rst_n(rst_n),
    .load(lock_load), .load_slot(lock_slot), .load_keep(lock_keep),
    .advance(lk_we), .keep_q(keep_q), .victim_q(victim_q)
  );

  xlat_lock_store #(.PN_W(PN_W), .LOCK_N(LOCK_N)) u_lock_store (
    .clk(clk), .rst_n(rst_n),
    .we(lk_we), .wr_slot(victim_q), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .inv_va(do_inv_va), .inv_vpn(inv_vpn),
    .lu_vpn(req_vpn), .lu_hit(lk_hit), .lu_ppn(lk_ppn)
  );

  xlat_set_store #(.PN_W(PN_W), .SET_N(SET_N), .WAY_N(WAY_N)) u_set_store (
    .clk(clk), .rst_n(rst_n),
    .we(sa_we), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .inv_all(do_inv_all), .inv_va(do_inv_va), .inv_vpn(inv_vpn),
    .lu_vpn(req_vpn), .lu_hit(sa_hit), .lu_ppn(sa_ppn)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      if (!mmu_en) begin
        rsp_hit <= 1'b1;
        rsp_ppn <= req_vpn;
      end else if (lk_hit) begin
        rsp_hit <= 1'b1;
        rsp_ppn <= lk_ppn;
      end else if (sa_hit) begin
        rsp_hit <= 1'b1;
        rsp_ppn <= sa_ppn;
      end else begin
        rsp_hit <= 1'b0;
        rsp_ppn <= '0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int PN_W   = 20,
  parameter int LOCK_N = 8,
  parameter int LK_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mmu_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PN_W-1:0] req_vpn,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_hit,
  input logic [PN_W-1:0] rsp_ppn,
  input logic            wr_en,
  input logic            lock_load,
  input logic [LK_W-1:0] lock_slot,
  input logic            lock_keep,
  input logic            inv_all,
  input logic            inv_va,
  input logic            keep_q,
  input logic [LK_W-1:0] victim_q
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ppn));

  a_r2_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !mmu_en |=> rsp_hit && (rsp_ppn == $past(req_vpn)));

  a_r5_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !inv_all && !inv_va && !lock_load && keep_q
    |=> (32'(victim_q) == (32'($past(victim_q)) + 1) % LOCK_N));

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_ppn == '0));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    lock_load |=> (victim_q == $past(lock_slot)) && (keep_q == $past(lock_keep)));
endmodule

bind xlat_buffer xlat_buffer_chk #(.PN_W(PN_W), .LOCK_N(LOCK_N), .LK_W(LK_W)) u_chk (.*);

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
  localparam int PN_W = 20;
  localparam int LK_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mmu_en = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PN_W-1:0] req_vpn = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit;
  logic [PN_W-1:0] rsp_ppn;
  logic wr_en = 1'b0;
  logic [PN_W-1:0] wr_vpn = '0;
  logic [PN_W-1:0] wr_ppn = '0;
  logic lock_load = 1'b0;
  logic [LK_W-1:0] lock_slot = '0;
  logic lock_keep = 1'b0;
  logic inv_all = 1'b0;
  logic inv_va = 1'b0;
  logic [PN_W-1:0] inv_vpn = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit              exp_hit_q[$];
  logic [PN_W-1:0] exp_ppn_q[$];
  string           exp_tag_q[$];

  always #2.5 clk = ~clk;

  xlat_buffer u0 (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .lock_load(lock_load), .lock_slot(lock_slot), .lock_keep(lock_keep),
    .inv_all(inv_all), .inv_va(inv_va), .inv_vpn(inv_vpn)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: pops expectations as responses are consumed
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_tag_q.size() == 0) begin
        chk("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        string t;
        bit h;
        logic [PN_W-1:0] p;
        t = exp_tag_q.pop_front();
        h = exp_hit_q.pop_front();
        p = exp_ppn_q.pop_front();
        chk({t, " hit"}, {31'd0, rsp_hit}, {31'd0, h});
        chk({t, " ppn"}, 32'(rsp_ppn), 32'(p));
      end
    end
  end

  task automatic push_exp(input string t, input bit h, input logic [PN_W-1:0] p);
    exp_tag_q.push_back(t);
    exp_hit_q.push_back(h);
    exp_ppn_q.push_back(p);
  endtask

  task automatic lookup(input logic [PN_W-1:0] v, input bit h, input logic [PN_W-1:0] p,
                        input string t);
    push_exp(t, h, p);
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = v;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_entry(input logic [PN_W-1:0] v, input logic [PN_W-1:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = v; wr_ppn = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_lock(input logic [LK_W-1:0] s, input bit k);
    @(negedge clk);
    lock_load = 1'b1; lock_slot = s; lock_keep = k;
    @(negedge clk);
    lock_load = 1'b0;
  endtask

  task automatic do_inv_all();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic do_inv_va(input logic [PN_W-1:0] v);
    @(negedge clk);
    inv_va = 1'b1; inv_vpn = v;
    @(negedge clk);
    inv_va = 1'b0;
  endtask

  task automatic set_en(input bit e);
    @(negedge clk);
    mmu_en = e;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: reset state
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 req_ready", {31'd0, req_ready}, 32'd1);
    lookup(20'h00123, 1'b0, 20'h0, "R12 empty");
    lookup(20'h00456, 1'b0, 20'h0, "R10 miss");

    // R3: bypass
    set_en(1'b0);
    lookup(20'h00ABC, 1'b1, 20'h00ABC, "R3 bypass");
    set_en(1'b1);

    // R4: set 5 round robin
    write_entry(20'h01005, 20'h11111);
    lookup(20'h01005, 1'b1, 20'h11111, "R4 way0");
    write_entry(20'h02005, 20'h22222);
    lookup(20'h01005, 1'b1, 20'h11111, "R4 way0 kept");
    lookup(20'h02005, 1'b1, 20'h22222, "R4 way1");
    write_entry(20'h03005, 20'h33333);
    lookup(20'h01005, 1'b0, 20'h0, "R4 evicted");
    lookup(20'h02005, 1'b1, 20'h22222, "R4 survivor");
    lookup(20'h03005, 1'b1, 20'h33333, "R4 new");

    // R5: locked writes and slot wrap
    load_lock(3'd6, 1'b1);
    write_entry(20'h04007, 20'h44444);           // slot 6
    write_entry(20'h05007, 20'h55555);           // slot 7
    for (int i = 0; i < 6; i++)
      write_entry(20'h00100 + PN_W'(i), 20'h00200 + PN_W'(i)); // slots 0..5
    write_entry(20'h07007, 20'h77777);           // slot 6 again
    lookup(20'h04007, 1'b0, 20'h0, "R5 overwritten");
    lookup(20'h07007, 1'b1, 20'h77777, "R5 wrapped");
    lookup(20'h05007, 1'b1, 20'h55555, "R5 slot7");
    lookup(20'h00103, 1'b1, 20'h00203, "R5 slot3");

    // R8: locked copy of a page already in the set store (slot 7)
    write_entry(20'h03005, 20'h99999);
    lookup(20'h03005, 1'b1, 20'h99999, "R8 lock wins");
    lookup(20'h05007, 1'b0, 20'h0, "R5 slot7 overwritten");

    // R6: invalidate all
    load_lock(3'd0, 1'b0);
    do_inv_all();
    lookup(20'h02005, 1'b0, 20'h0, "R6 set cleared");
    lookup(20'h03005, 1'b1, 20'h99999, "R6 lock kept");
    lookup(20'h07007, 1'b1, 20'h77777, "R6 lock kept2");

    // R7: invalidate by address, both stores
    write_entry(20'h07007, 20'h12345);
    lookup(20'h07007, 1'b1, 20'h77777, "R8 lock over set");
    do_inv_va(20'h07007);
    lookup(20'h07007, 1'b0, 20'h0, "R7 both cleared");
    lookup(20'h00100, 1'b1, 20'h00200, "R7 other kept");

    // R9: retention across disable
    set_en(1'b0);
    lookup(20'h00101, 1'b1, 20'h00101, "R9 bypass");
    set_en(1'b1);
    lookup(20'h00101, 1'b1, 20'h00201, "R9 retained");

    // R11: invalidate beats write in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = 20'h08009; wr_ppn = 20'hAAAAA;
    inv_va = 1'b1; inv_vpn = 20'h00102;
    @(negedge clk);
    wr_en = 1'b0; inv_va = 1'b0;
    lookup(20'h08009, 1'b0, 20'h0, "R11 write dropped");
    lookup(20'h00102, 1'b0, 20'h0, "R11 inv applied");

    // R11: write with lock load uses old keep bit (0)
    @(negedge clk);
    wr_en = 1'b1; wr_vpn = 20'h09009; wr_ppn = 20'hBBBBB;
    lock_load = 1'b1; lock_slot = 3'd3; lock_keep = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lock_load = 1'b0;
    lookup(20'h09009, 1'b1, 20'hBBBBB, "R11 old keep");
    write_entry(20'h0A00A, 20'hCCCCC);           // now locked slot 3
    lookup(20'h00103, 1'b0, 20'h0, "R11 new slot used");
    lookup(20'h0A00A, 1'b1, 20'hCCCCC, "R11 locked write");

    // R2: stall with a second request waiting
    @(negedge clk);
    rsp_ready = 1'b0;
    push_exp("R2 first", 1'b1, 20'hCCCCC);
    req_valid = 1'b1; req_vpn = 20'h0A00A;
    @(negedge clk);
    req_vpn = 20'h09009;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R2 valid held", {31'd0, rsp_valid}, 32'd1);
      chk("R2 ready low", {31'd0, req_ready}, 32'd0);
      chk("R2 ppn held", 32'(rsp_ppn), 32'h000CCCCC);
    end
    push_exp("R2 second", 1'b1, 20'hBBBBB);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    repeat (5) @(negedge clk);
    chk("R1 all responses", 32'(exp_tag_q.size()), 32'd0);
    finish_run();
  end
endmodule